// File: doc/BRIEF.md
# Descriptor-Chained SPI Transfer Sequencer

This block walks a linked list of transfer descriptors stored in a small register array. It turns each descriptor into a run of unit requests for an external SPI shifter. A descriptor sets the lane width, where transmit data comes from (off, FIFO, constant zeros or constant ones), whether receive is on, the unit size, the number of units, and whether chip select drops once the descriptor finishes. Each descriptor also names its successor and can carry an end-of-chain flag.

Software fills the array through a write port and writes a control word. In chained mode the control word names the first descriptor. Otherwise the control word is itself a one-shot descriptor. Software then pulses the execute command bits to start, stop or flush FIFOs. The shifter sees one request at a time, with the fields of the running descriptor, and answers each unit with a one-cycle acknowledge. A status word reports done, programming error, the busy flag and the index currently being executed.

Top module: `spi_desc_seq`

## Requirements
- R1: After reset, status_o is zero and cs_o and unit_req_o are low.
- R2: exec_i bit 0 while idle starts a run. The busy flag (status bit 16) is high after the first edge, and unit_req_o is high after the second edge. While unit_req_o is high: unit_width_o carries descriptor bits 1:0 (0 single, 1 dual, 2 quad); unit_tx_src_o carries bits 3:2 (0 off, 1 FIFO, 2 zeros, 3 ones); unit_rx_en_o carries bit 6; unit_bits_o is 1, 8, 32 or 128 for a bits 11:10 value of 0, 1, 2 or 3.
- R3: A descriptor produces exactly as many unit requests as its count field, bits 31:17. Each request is retired by one unit_ack_i.
- R4: When a descriptor without the end flag (bit 16) completes, unit_req_o is low for one cycle. The descriptor at the index in bits 15:12 then drives the request fields.
- R5: When a descriptor with the end flag completes, status bit 0 (done) sets, the busy flag clears and requests stop.
- R6: When a descriptor with bit 9 set completes, cs_o deasserts. Without bit 9, cs_o stays asserted into the following descriptor. cs_o is high whenever unit_req_o is high.
- R7: A fetched descriptor with transmit source 0 and bit 6 clear, or with a zero count, sets status bit 4 (programming error). It issues no request and leaves cs_o low and the block idle.
- R8: exec_i bit 1 during a run lets the unit in progress complete, then deasserts cs_o, sets done and returns to idle, leaving remaining units unsent.
- R9: Status bits 27:24 report the index of the descriptor being fetched or executed.
- R10: Writing a 1 to status_clr_i bit 0 or bit 4 clears done or programming error on the next edge. Otherwise both flags hold.
- R11: With control bit 16 clear, the control word is run as a single descriptor and treated as the end of the chain, whatever its bits 16:12 hold.
- R12: exec_i bit 2 produces a one-cycle fifo_clr_o pulse on the following cycle and does not start a run.
- R13: A start command while a run is busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| desc_we_i | input | 1 | Descriptor array write strobe |
| desc_widx_i | input | 4 | Descriptor array write index |
| desc_wdata_i | input | 32 | Descriptor word to write |
| ctrl_we_i | input | 1 | Control word write strobe |
| ctrl_wdata_i | input | 32 | Control word (bit 16 chain mode, 15:12 first index) |
| exec_i | input | 3 | Command pulses: bit 0 start, bit 1 stop, bit 2 flush FIFOs |
| status_clr_i | input | 32 | Write-1-to-clear mask for status |
| unit_ack_i | input | 1 | Shifter finished the requested unit |
| unit_req_o | output | 1 | Unit request to the shifter |
| unit_width_o | output | 2 | Lane width of the unit |
| unit_tx_src_o | output | 2 | Transmit source of the unit |
| unit_rx_en_o | output | 1 | Receive enable of the unit |
| unit_bits_o | output | 8 | Bits per unit |
| cs_o | output | 1 | Chip select asserted |
| fifo_clr_o | output | 1 | FIFO flush pulse |
| status_o | output | 32 | Done (0), prog error (4), busy (16), index (27:24) |

## Verification
Commands are sampled on one rising edge. The busy flag and the flush pulse are due one edge later, and the first unit request two edges later. A completed descriptor shows its effect on cs_o, done and the index field on the edge that takes its final acknowledge. The next request in a chain follows one edge after that. The bench drives every input on the falling edge and checks outputs on the falling edge after the exact number of rising edges counted above. A scoreboard of expected unit fields, filled before each start, is compared on every request seen by the acknowledging monitor.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
  localparam int WORD_W = 32;
  localparam int CNT_W  = 15;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_RUN} seq_state_e;

  typedef struct packed {
    logic [CNT_W-1:0] count;
    logic             last;
    logic [3:0]       next_idx;
    logic [1:0]       unit_sz;
    logic             close_cs;
    logic             rx_en;
    logic [1:0]       tx_src;
    logic [1:0]       width;
  } desc_t;

  function automatic logic [7:0] unit_bits(input logic [1:0] sz);
    case (sz)
      2'd0:    return 8'd1;
      2'd1:    return 8'd8;
      2'd2:    return 8'd32;
      default: return 8'd128;
    endcase
  endfunction
endpackage

// File: rtl/spi_desc_regfile.sv
module spi_desc_regfile #(
  parameter int NUM_DESC = 16,
  parameter int WORD_W   = 32,
  localparam int IDX_W   = $clog2(NUM_DESC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  ridx_i,
  output logic [WORD_W-1:0] rdata_o
);
  logic [WORD_W-1:0] mem [NUM_DESC];

  for (genvar g = 0; g < NUM_DESC; g++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem[g] <= '0;
      else if (we_i && (widx_i == IDX_W'(g))) mem[g] <= wdata_i;
    end
  end

  assign rdata_o = mem[ridx_i];
endmodule

// File: rtl/spi_desc_check.sv
module spi_desc_check
  import spi_seq_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  logic              force_last_i,
  output desc_t             desc_o,
  output logic              ok_o
);
  logic unused_bits;
  assign unused_bits = ^{word_i[8:7], word_i[5:4]};

  always_comb begin
    desc_o.width    = word_i[1:0];
    desc_o.tx_src   = word_i[3:2];
    desc_o.rx_en    = word_i[6];
    desc_o.close_cs = word_i[9];
    desc_o.unit_sz  = word_i[11:10];
    desc_o.next_idx = word_i[15:12];
    desc_o.last     = word_i[16] | force_last_i;
    desc_o.count    = word_i[31:17];
    // a descriptor must move data in at least one direction and at least one unit
    ok_o = ((word_i[3:2] != 2'd0) || word_i[6]) && (word_i[31:17] != '0);
  end
endmodule

// File: rtl/spi_seq_ctrl.sv
module spi_seq_ctrl
  import spi_seq_pkg::*;
#(
  parameter int NUM_DESC = 16,
  localparam int IDX_W   = $clog2(NUM_DESC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [IDX_W-1:0] first_idx_i,
  input  desc_t            fetch_desc_i,
  input  logic             fetch_ok_i,
  input  logic             unit_ack_i,
  input  logic             clr_done_i,
  input  logic             clr_err_i,
  output logic [IDX_W-1:0] idx_o,
  output desc_t            cur_o,
  output logic             unit_req_o,
  output logic             cs_o,
  output logic             done_o,
  output logic             err_o,
  output logic             active_o
);
  seq_state_e       state_q;
  logic [CNT_W-1:0] remain_q;
  logic             stop_pend_q;
  logic             stop_any;

  assign stop_any   = stop_i | stop_pend_q;
  assign unit_req_o = (state_q == ST_RUN);
  assign active_o   = (state_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      idx_o       <= '0;
      cur_o       <= '0;
      remain_q    <= '0;
      stop_pend_q <= 1'b0;
      cs_o        <= 1'b0;
      done_o      <= 1'b0;
      err_o       <= 1'b0;
    end else begin
      if (clr_done_i) done_o <= 1'b0;
      if (clr_err_i)  err_o  <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q     <= ST_FETCH;
            idx_o       <= first_idx_i;
            stop_pend_q <= 1'b0;
          end
        end
        ST_FETCH: begin
          if (stop_any) begin
            state_q <= ST_IDLE;
            cs_o    <= 1'b0;
            done_o  <= 1'b1;
          end else if (!fetch_ok_i) begin
            state_q <= ST_IDLE;
            cs_o    <= 1'b0;
            err_o   <= 1'b1;
          end else begin
            state_q  <= ST_RUN;
            cur_o    <= fetch_desc_i;
            remain_q <= fetch_desc_i.count;
            cs_o     <= 1'b1;
          end
        end
        ST_RUN: begin
          if (stop_i) stop_pend_q <= 1'b1;
          if (unit_ack_i) begin
            if (stop_any) begin
              state_q <= ST_IDLE;
              cs_o    <= 1'b0;
              done_o  <= 1'b1;
            end else if (remain_q == CNT_W'(1)) begin
              if (cur_o.close_cs) cs_o <= 1'b0;
              if (cur_o.last) begin
                state_q <= ST_IDLE;
                done_o  <= 1'b1;
              end else begin
                state_q <= ST_FETCH;
                idx_o   <= IDX_W'(cur_o.next_idx);
              end
            end else begin
              remain_q <= remain_q - CNT_W'(1);
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_desc_seq.sv
module spi_desc_seq
  import spi_seq_pkg::*;
#(
  parameter int NUM_DESC = 16,
  localparam int IDX_W   = $clog2(NUM_DESC)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        desc_we_i,
  input  logic [3:0]  desc_widx_i,
  input  logic [31:0] desc_wdata_i,
  input  logic        ctrl_we_i,
  input  logic [31:0] ctrl_wdata_i,
  input  logic [2:0]  exec_i,
  input  logic [31:0] status_clr_i,
  input  logic        unit_ack_i,
  output logic        unit_req_o,
  output logic [1:0]  unit_width_o,
  output logic [1:0]  unit_tx_src_o,
  output logic        unit_rx_en_o,
  output logic [7:0]  unit_bits_o,
  output logic        cs_o,
  output logic        fifo_clr_o,
  output logic [31:0] status_o
);
  logic [31:0]      ctrl_q;
  logic [31:0]      mem_word;
  logic [31:0]      fetch_word;
  logic             chain_mode;
  logic [IDX_W-1:0] rd_idx;
  desc_t            fetch_desc;
  desc_t            cur_desc;
  logic             fetch_ok;
  logic             done, err, active;
  logic [3:0]       idx_ext;
  logic             unused_clr;

  assign unused_clr = ^{status_clr_i[31:5], status_clr_i[3:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q     <= '0;
      fifo_clr_o <= 1'b0;
    end else begin
      if (ctrl_we_i) ctrl_q <= ctrl_wdata_i;
      fifo_clr_o <= exec_i[2];
    end
  end

  assign chain_mode = ctrl_q[16];
  assign fetch_word = chain_mode ? mem_word : ctrl_q;

  spi_desc_regfile #(.NUM_DESC(NUM_DESC), .WORD_W(WORD_W)) i_regfile (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (desc_we_i),
    .widx_i (IDX_W'(desc_widx_i)),
    .wdata_i(desc_wdata_i),
    .ridx_i (rd_idx),
    .rdata_o(mem_word)
  );

  spi_desc_check i_check (
    .word_i      (fetch_word),
    .force_last_i(~chain_mode),
    .desc_o      (fetch_desc),
    .ok_o        (fetch_ok)
  );

  spi_seq_ctrl #(.NUM_DESC(NUM_DESC)) i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (exec_i[0]),
    .stop_i      (exec_i[1]),
    .first_idx_i (IDX_W'(ctrl_q[15:12])),
    .fetch_desc_i(fetch_desc),
    .fetch_ok_i  (fetch_ok),
    .unit_ack_i  (unit_ack_i),
    .clr_done_i  (status_clr_i[0]),
    .clr_err_i   (status_clr_i[4]),
    .idx_o       (rd_idx),
    .cur_o       (cur_desc),
    .unit_req_o  (unit_req_o),
    .cs_o        (cs_o),
    .done_o      (done),
    .err_o       (err),
    .active_o    (active)
  );

  assign unit_width_o  = cur_desc.width;
  assign unit_tx_src_o = cur_desc.tx_src;
  assign unit_rx_en_o  = cur_desc.rx_en;
  assign unit_bits_o   = unit_bits(cur_desc.unit_sz);

  assign idx_ext  = 4'(rd_idx);
  assign status_o = {4'b0, idx_ext, 7'b0, active, 11'b0, err, 3'b0, done};
endmodule

// File: rtl/spi_desc_seq_chk.sv
module spi_desc_seq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [2:0]  exec_i,
  input logic [31:0] status_clr_i,
  input logic        unit_ack_i,
  input logic        unit_req_o,
  input logic [1:0]  unit_width_o,
  input logic [1:0]  unit_tx_src_o,
  input logic        unit_rx_en_o,
  input logic [7:0]  unit_bits_o,
  input logic        cs_o,
  input logic        fifo_clr_o,
  input logic [31:0] status_o
);
  AST_REQ_HAS_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unit_req_o |-> cs_o); // R6
  AST_REQ_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unit_req_o |-> status_o[16]); // R5
  AST_DONE_ENDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[0]) |-> !unit_req_o); // R5
  AST_ERR_NO_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[4]) |-> (!unit_req_o && !status_o[16] && !cs_o)); // R7
  AST_FLUSH_FROM_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_clr_o |-> $past(exec_i[2])); // R12
  AST_DONE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[0] && !status_clr_i[0]) |=> status_o[0]); // R10
  AST_FIELDS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unit_req_o && !unit_ack_i) |=>
      $stable({unit_width_o, unit_tx_src_o, unit_rx_en_o, unit_bits_o})); // R2
endmodule

bind spi_desc_seq spi_desc_seq_chk i_spi_desc_seq_chk (.*);

// File: tb/test_spi_desc_seq.sv
module test_spi_desc_seq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        desc_we_i = 1'b0;
  logic [3:0]  desc_widx_i = '0;
  logic [31:0] desc_wdata_i = '0;
  logic        ctrl_we_i = 1'b0;
  logic [31:0] ctrl_wdata_i = '0;
  logic [2:0]  exec_i = '0;
  logic [31:0] status_clr_i = '0;
  logic        unit_ack_i = 1'b0;
  logic        unit_req_o, unit_rx_en_o, cs_o, fifo_clr_o;
  logic [1:0]  unit_width_o, unit_tx_src_o;
  logic [7:0]  unit_bits_o;
  logic [31:0] status_o;

  int checks = 0;
  int fails = 0;
  bit mon_en = 1'b0;
  logic [12:0] exp_q[$];

  spi_desc_seq i_spi_desc_seq (.*);

  always #5 clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int w, input int src, input bit rx, input bit cls,
                                     input int usz, input int nxt, input bit lst, input int cnt);
    return {cnt[14:0], lst, nxt[3:0], usz[1:0], cls, 2'b00, rx, 2'b00, src[1:0], w[1:0]};
  endfunction

  function automatic logic [12:0] exp_of(input logic [31:0] d);
    logic [7:0] b;
    case (d[11:10]) 2'd0: b = 1; 2'd1: b = 8; 2'd2: b = 32; default: b = 128; endcase
    return {d[1:0], d[3:2], d[6], b};
  endfunction

  task automatic push_units(input logic [31:0] d, input int n);
    for (int i = 0; i < n; i++) exp_q.push_back(exp_of(d));
  endtask

  task automatic wr_desc(input int idx, input logic [31:0] d);
    @(negedge clk_i); desc_we_i = 1; desc_widx_i = idx[3:0]; desc_wdata_i = d;
    @(negedge clk_i); desc_we_i = 0;
  endtask

  task automatic wr_ctrl(input logic [31:0] d);
    @(negedge clk_i); ctrl_we_i = 1; ctrl_wdata_i = d;
    @(negedge clk_i); ctrl_we_i = 0;
  endtask

  task automatic cmd(input logic [2:0] b);
    @(negedge clk_i); exec_i = b;
    @(negedge clk_i); exec_i = '0;
  endtask

  task automatic clr_sts(input logic [31:0] m);
    @(negedge clk_i); status_clr_i = m;
    @(negedge clk_i); status_clr_i = '0;
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    while (status_o[16] && n < 3000) begin @(negedge clk_i); n++; end
    chk(n < 3000, req, n, 0);
  endtask

  // monitor: acknowledges every request and compares it against the scoreboard
  initial begin
    forever begin
      @(negedge clk_i);
      if (mon_en) begin
        if (unit_ack_i) unit_ack_i = 1'b0;
        else if (unit_req_o) begin
          logic [12:0] act;
          act = {unit_width_o, unit_tx_src_o, unit_rx_en_o, unit_bits_o};
          if (exp_q.size() == 0) chk(1'b0, "R3 unexpected unit", act, 0);
          else begin
            logic [12:0] e;
            e = exp_q.pop_front();
            chk(act == e, "R2/R4 unit fields", act, e);
          end
          unit_ack_i = 1'b1;
        end
      end
    end
  end

  initial begin
    #(10 * 150000);
    chk(1'b0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d0, d5, da, db, dc, d;
    int left;
    repeat (3) @(negedge clk_i);
    // R1
    chk(status_o == 0, "R1 status", status_o, 0);
    chk(!cs_o && !unit_req_o, "R1 cs/req", {cs_o, unit_req_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2 R4 R6 R9 R5: cycle-exact two-link chain with manual acks
    d0 = mk(2, 3, 0, 0, 1, 5, 0, 1);
    d5 = mk(1, 0, 1, 1, 2, 0, 1, 1);
    wr_desc(0, d0); wr_desc(5, d5);
    wr_ctrl(32'h0001_0000);
    cmd(3'b001);
    chk(status_o[16] && !unit_req_o, "R2 busy before request", {status_o[16], unit_req_o}, 2);
    @(negedge clk_i);
    chk(unit_req_o && cs_o, "R2 request after second edge", {unit_req_o, cs_o}, 3);
    chk({unit_width_o, unit_tx_src_o, unit_rx_en_o, unit_bits_o} == exp_of(d0), "R2 fields",
        {unit_width_o, unit_tx_src_o, unit_rx_en_o, unit_bits_o}, exp_of(d0));
    chk(status_o[27:24] == 0, "R9 index 0", status_o[27:24], 0);
    unit_ack_i = 1;
    @(negedge clk_i); unit_ack_i = 0;
    chk(!unit_req_o && cs_o, "R4 gap, R6 cs held", {unit_req_o, cs_o}, 1);
    chk(status_o[27:24] == 5, "R9 index next", status_o[27:24], 5);
    @(negedge clk_i);
    chk(unit_req_o && {unit_width_o, unit_tx_src_o, unit_rx_en_o, unit_bits_o} == exp_of(d5),
        "R4 next descriptor", {unit_width_o, unit_tx_src_o, unit_rx_en_o, unit_bits_o}, exp_of(d5));
    unit_ack_i = 1;
    @(negedge clk_i); unit_ack_i = 0;
    chk(!cs_o, "R6 close", cs_o, 0);
    chk(status_o[0] && !status_o[16] && !unit_req_o, "R5 done", status_o, 32'h1);

    // R10
    clr_sts(32'h1);
    chk(status_o[0] == 0, "R10 done cleared", status_o[0], 0);
    repeat (2) @(negedge clk_i);
    chk(status_o[0] == 0, "R10 stays clear", status_o[0], 0);

    // R3 R4: three-link chain through the scoreboard
    mon_en = 1;
    da = mk(0, 1, 1, 0, 0, 7, 0, 3);
    db = mk(2, 2, 0, 0, 3, 3, 0, 2);
    dc = mk(1, 1, 0, 1, 1, 0, 1, 4);
    wr_desc(2, da); wr_desc(7, db); wr_desc(3, dc);
    push_units(da, 3); push_units(db, 2); push_units(dc, 4);
    wr_ctrl(32'h0001_2000);
    cmd(3'b001);
    wait_idle("R3 chain timeout");
    repeat (2) @(negedge clk_i);
    chk(exp_q.size() == 0, "R3 all units used", exp_q.size(), 0);
    chk(status_o[0] && !cs_o, "R5 chain done", {status_o[0], cs_o}, 2);
    clr_sts(32'h11);

    // R7: no direction enabled
    wr_desc(8, mk(0, 0, 0, 1, 1, 0, 1, 2));
    wr_ctrl(32'h0001_8000);
    cmd(3'b001);
    @(negedge clk_i);
    chk(status_o[4] && !status_o[16] && !cs_o && !unit_req_o, "R7 no direction",
        status_o, 32'h0800_0010);
    // R10 clear of error
    clr_sts(32'h10);
    chk(status_o[4] == 0, "R10 error cleared", status_o[4], 0);
    // R7: zero count
    wr_desc(9, mk(0, 1, 0, 1, 1, 0, 1, 0));
    wr_ctrl(32'h0001_9000);
    cmd(3'b001);
    @(negedge clk_i);
    chk(status_o[4] && !cs_o && !unit_req_o && !status_o[0], "R7 zero count", status_o, 32'h0900_0010);
    clr_sts(32'h11);

    // R8: stop in the middle of a long descriptor
    d = mk(0, 1, 0, 1, 1, 0, 1, 100);
    wr_desc(10, d);
    push_units(d, 100);
    wr_ctrl(32'h0001_A000);
    cmd(3'b001);
    repeat (9) @(negedge clk_i);
    cmd(3'b010);
    wait_idle("R8 stop timeout");
    repeat (2) @(negedge clk_i);
    left = exp_q.size();
    chk(left > 0 && left < 100, "R8 units left unsent", left, 95);
    chk(status_o[0] && !cs_o && !unit_req_o, "R8 done, cs off", {status_o[0], cs_o, unit_req_o}, 4);
    exp_q.delete();
    clr_sts(32'h11);

    // R11: control word as a single descriptor, end flag forced
    d = mk(1, 2, 1, 1, 2, 9, 0, 2);
    push_units(d, 2);
    wr_ctrl(d);
    cmd(3'b001);
    wait_idle("R11 timeout");
    repeat (2) @(negedge clk_i);
    chk(exp_q.size() == 0 && status_o[0], "R11 single run", exp_q.size(), 0);
    clr_sts(32'h11);

    // R13: second start during a run is ignored
    d = mk(0, 3, 0, 1, 1, 0, 1, 6);
    wr_desc(11, d);
    push_units(d, 6);
    wr_ctrl(32'h0001_B000);
    cmd(3'b001);
    repeat (3) @(negedge clk_i);
    cmd(3'b001);
    wait_idle("R13 timeout");
    repeat (4) @(negedge clk_i);
    chk(exp_q.size() == 0 && !status_o[16] && !unit_req_o, "R13 no restart", exp_q.size(), 0);
    clr_sts(32'h11);

    // R12: flush pulse
    cmd(3'b100);
    chk(fifo_clr_o, "R12 pulse", fifo_clr_o, 1);
    @(negedge clk_i);
    chk(!fifo_clr_o && !status_o[16], "R12 one cycle, no start", {fifo_clr_o, status_o[16]}, 0);

    mon_en = 0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule